// File: doc/BRIEF.md
# Clock synthesizer reconfiguration sequencer

This block reprograms the multiply and divide ratio of a frequency-synthesizing clock manager while the chip is running. It reaches the clock manager through a small register port with address, write data, read data, an enable strobe, a write-enable and a ready reply. A user raises a one-cycle start strobe together with the desired multiplier and divisor. The sequencer then takes the clock manager through a fixed update ritual and reports done or error.

The ritual has nine named states. From IDLE, a valid request goes to ASSERT_RST, where the manager reset is raised. The sequence then passes through WRITE_M, WRITE_D and READ_ADDR0, with the reset held during all three accesses. RELEASE_RST drops the reset, and WAIT_LOCK waits for the manager to report lock. The sequence ends in DONE, or in ERROR on an out-of-range request or on a timeout. Each stored value is the requested value minus one. The read of address 0 returns the manager's data output to its default status and must finish before reset is released.

Transitions: IDLE→ASSERT_RST (valid start), IDLE→ERROR (rejected start), ASSERT_RST→WRITE_M, WRITE_M→WRITE_D, WRITE_D→READ_ADDR0 and READ_ADDR0→RELEASE_RST (each on ready), any access state→ERROR (ready timeout), RELEASE_RST→WAIT_LOCK, WAIT_LOCK→DONE (lock high), WAIT_LOCK→ERROR (lock timeout), DONE→IDLE, ERROR→IDLE.

Top module: `clkgen_reprog_seq`

## Requirements
- R1: A start with multiplier or divisor below 2 or above 2**VAL_W (32 by default) raises err for exactly the next cycle. busy stays low and drp_en is never asserted for that request.
- R2: After an accepted start, busy is high from the next cycle until the cycle done or err is high. done and err are one-cycle pulses that are never high together, and busy is low while either is high.
- R3: An accepted sequence makes exactly three accesses in this order: a write (drp_we=1) of multiplier-1 to address ADDR_M, a write of divisor-1 to ADDR_D, and a read (drp_we=0) of address 0. Values are zero-extended into drp_wdata.
- R4: cm_rst is high in the cycle before the first access starts and stays high through all three accesses.
- R5: cm_rst falls only after the ready of the address-0 read. done pulses one cycle after cm_locked is seen high in WAIT_LOCK.
- R6: drp_en is high for exactly one cycle per access. No new access starts until ready has answered the previous one.
- R7: The read data returned with the ready of the address-0 read appears on stat_rdata when done is reported.
- R8: A start strobe while busy is ignored. The running sequence still writes the originally latched values and makes only three accesses.
- R9: If ready does not arrive within RDY_LIMIT cycles of an access, err pulses with cm_rst low and no further access is made.
- R10: If cm_locked does not rise within LOCK_LIMIT cycles in WAIT_LOCK, err pulses with cm_rst low and done is not reported.
- R11: Synchronous active-high rst returns the block to IDLE. busy, done, err, cm_rst and drp_en all read 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request strobe |
| req_mult | input | VAL_W+1 | Desired multiplier |
| req_div | input | VAL_W+1 | Desired divisor |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle error pulse (range or timeout) |
| stat_rdata | output | DATA_W | Data captured by the address-0 read |
| cm_rst | output | 1 | Reset to the clock manager |
| drp_addr | output | ADDR_W | Register port address |
| drp_wdata | output | DATA_W | Register port write data |
| drp_en | output | 1 | Register port access strobe |
| drp_we | output | 1 | Register port write-enable |
| drp_rdy | input | 1 | Register port ready reply |
| drp_rdata | input | DATA_W | Register port read data |
| cm_locked | input | 1 | Clock manager lock indication |

## Verification
A rejected start is checked on the first falling edge after the edge that samples it: err must be high and busy low. An accepted start is checked at that same point for busy. A passive monitor records every access at the edge it is strobed, so order, addresses, data and the reset level can be compared after done, whatever the ready latency (1 to 4 cycles) and lock delay (3 to 20 cycles). Timeouts are checked by counting falling edges from the stalled strobe to err, against a window of RDY_LIMIT plus the two register stages. done is checked in the cycle it appears, against the modelled lock level.

// File: rtl/clkgen_reprog_pkg.sv
package clkgen_reprog_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ASSERT_RST,
        S_WRITE_M,
        S_WRITE_D,
        S_READ_ADDR0,
        S_RELEASE_RST,
        S_WAIT_LOCK,
        S_DONE,
        S_ERROR
    } seq_state_t;

endpackage

// File: rtl/clkgen_ratio_check.sv
module clkgen_ratio_check #(
    parameter int VAL_W = 5
) (
    input  logic [VAL_W:0]   mult,
    input  logic [VAL_W:0]   div,
    output logic             ok,
    output logic [VAL_W-1:0] mult_enc,
    output logic [VAL_W-1:0] div_enc
);
    localparam logic [VAL_W:0] MIN_V = (VAL_W+1)'(2);
    localparam logic [VAL_W:0] MAX_V = (VAL_W+1)'(2 ** VAL_W);
    localparam logic [VAL_W:0] ONE   = (VAL_W+1)'(1);

    always_comb begin
        ok       = (mult >= MIN_V) && (mult <= MAX_V) &&
                   (div  >= MIN_V) && (div  <= MAX_V);
        mult_enc = VAL_W'(mult - ONE);
        div_enc  = VAL_W'(div - ONE);
    end
endmodule

// File: rtl/clkgen_wait_timer.sv
module clkgen_wait_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/clkgen_drp_access.sv
module clkgen_drp_access #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic              abort,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] drp_addr,
    output logic [DATA_W-1:0] drp_wdata,
    output logic              drp_en,
    output logic              drp_we,
    input  logic              drp_rdy,
    input  logic [DATA_W-1:0] drp_rdata,
    output logic              pending,
    output logic              ack,
    output logic [DATA_W-1:0] rdata_q
);
    logic we_q;

    assign drp_en    = kick;
    assign drp_we    = kick && is_write;
    assign drp_addr  = addr;
    assign drp_wdata = wdata;
    assign ack       = pending && drp_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            we_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (kick) begin
                pending <= 1'b1;
                we_q    <= is_write;
            end else if (ack || abort) begin
                pending <= 1'b0;
            end
            if (ack && !we_q)
                rdata_q <= drp_rdata;
        end
    end
endmodule

// File: rtl/clkgen_reprog_seq.sv
module clkgen_reprog_seq
    import clkgen_reprog_pkg::*;
#(
    parameter int              VAL_W      = 5,
    parameter int              ADDR_W     = 7,
    parameter int              DATA_W     = 16,
    parameter logic [ADDR_W-1:0] ADDR_M   = 7'h50,
    parameter logic [ADDR_W-1:0] ADDR_D   = 7'h52,
    parameter int              RDY_LIMIT  = 32,
    parameter int              LOCK_LIMIT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic [VAL_W:0]    req_mult,
    input  logic [VAL_W:0]    req_div,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] stat_rdata,
    output logic              cm_rst,
    output logic [ADDR_W-1:0] drp_addr,
    output logic [DATA_W-1:0] drp_wdata,
    output logic              drp_en,
    output logic              drp_we,
    input  logic              drp_rdy,
    input  logic [DATA_W-1:0] drp_rdata,
    input  logic              cm_locked
);
    localparam logic [ADDR_W-1:0] ADDR_STATUS = '0;
    localparam int PAD_W = DATA_W - VAL_W;

    seq_state_t state_q, state_d;
    logic [VAL_W-1:0] mult_q, div_q;
    logic [VAL_W-1:0] mult_enc, div_enc;
    logic             ratio_ok;

    logic              kick, is_write, pending, ack;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic              rdy_expired, lock_expired;

    clkgen_ratio_check #(.VAL_W(VAL_W)) ratio_i (
        .mult     (req_mult),
        .div      (req_div),
        .ok       (ratio_ok),
        .mult_enc (mult_enc),
        .div_enc  (div_enc)
    );

    clkgen_drp_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick),
        .abort     (rdy_expired),
        .is_write  (is_write),
        .addr      (acc_addr),
        .wdata     (acc_wdata),
        .drp_addr  (drp_addr),
        .drp_wdata (drp_wdata),
        .drp_en    (drp_en),
        .drp_we    (drp_we),
        .drp_rdy   (drp_rdy),
        .drp_rdata (drp_rdata),
        .pending   (pending),
        .ack       (ack),
        .rdata_q   (stat_rdata)
    );

    clkgen_wait_timer #(.LIMIT(RDY_LIMIT)) rdy_tmr_i (
        .clk     (clk),
        .rst     (rst),
        .run     (pending && !drp_rdy),
        .expired (rdy_expired)
    );

    clkgen_wait_timer #(.LIMIT(LOCK_LIMIT)) lock_tmr_i (
        .clk     (clk),
        .rst     (rst),
        .run     ((state_q == S_WAIT_LOCK) && !cm_locked),
        .expired (lock_expired)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:        if (req_start) state_d = ratio_ok ? S_ASSERT_RST : S_ERROR;
            S_ASSERT_RST:  state_d = S_WRITE_M;
            S_WRITE_M:     if (ack) state_d = S_WRITE_D;
                           else if (rdy_expired) state_d = S_ERROR;
            S_WRITE_D:     if (ack) state_d = S_READ_ADDR0;
                           else if (rdy_expired) state_d = S_ERROR;
            S_READ_ADDR0:  if (ack) state_d = S_RELEASE_RST;
                           else if (rdy_expired) state_d = S_ERROR;
            S_RELEASE_RST: state_d = S_WAIT_LOCK;
            S_WAIT_LOCK:   if (cm_locked) state_d = S_DONE;
                           else if (lock_expired) state_d = S_ERROR;
            S_DONE:        state_d = S_IDLE;
            S_ERROR:       state_d = S_IDLE;
            default:       state_d = S_IDLE;
        endcase
    end

    // state register and latched ratio
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            mult_q  <= '0;
            div_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_start && ratio_ok) begin
                mult_q <= mult_enc;
                div_q  <= div_enc;
            end
        end
    end

    // outputs
    always_comb begin
        kick      = 1'b0;
        is_write  = 1'b0;
        acc_addr  = ADDR_STATUS;
        acc_wdata = '0;
        cm_rst    = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            S_IDLE:        busy = 1'b0;
            S_ASSERT_RST:  cm_rst = 1'b1;
            S_WRITE_M: begin
                cm_rst    = 1'b1;
                kick      = !pending;
                is_write  = 1'b1;
                acc_addr  = ADDR_M;
                acc_wdata = {{PAD_W{1'b0}}, mult_q};
            end
            S_WRITE_D: begin
                cm_rst    = 1'b1;
                kick      = !pending;
                is_write  = 1'b1;
                acc_addr  = ADDR_D;
                acc_wdata = {{PAD_W{1'b0}}, div_q};
            end
            S_READ_ADDR0: begin
                cm_rst = 1'b1;
                kick   = !pending;
            end
            S_RELEASE_RST: ;
            S_WAIT_LOCK:   ;
            S_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            S_ERROR: begin
                busy = 1'b0;
                err  = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkgen_reprog_seq_chk.sv
module clkgen_reprog_seq_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic err,
    input logic cm_rst,
    input logic drp_en,
    input logic cm_locked
);
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !drp_en);                                   // R1
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        done |-> !err);                                       // R2
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> !busy);                             // R2
    AST_ACCESS_UNDER_RST: assert property (@(posedge clk) disable iff (rst)
        drp_en |-> cm_rst);                                   // R4
    AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cm_locked));                           // R5
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        drp_en |=> !drp_en);                                  // R6
    AST_ERR_RELEASED: assert property (@(posedge clk) disable iff (rst)
        err |-> !cm_rst);                                     // R9
endmodule

bind clkgen_reprog_seq clkgen_reprog_seq_chk chk_i (.*);

// File: tb/clkgen_reprog_seq_tb_top.sv
module clkgen_reprog_seq_tb_top;
    localparam int VW = 5;
    localparam int AW = 7;
    localparam int DW = 16;
    localparam int RL = 32;
    localparam int LL = 256;
    localparam logic [AW-1:0] AM = 7'h50;
    localparam logic [AW-1:0] AD = 7'h52;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_start = 1'b0;
    logic [VW:0] req_mult = '0, req_div = '0;
    logic busy, done, err, cm_rst, drp_en, drp_we;
    logic [DW-1:0] stat_rdata, drp_wdata;
    logic [AW-1:0] drp_addr;
    logic drp_rdy = 1'b0;
    logic [DW-1:0] drp_rdata = '0;
    logic cm_locked = 1'b1;

    int n_checks = 0, n_errors = 0;
    bit stall = 0, lock_never = 0;
    int lock_dly = 5;

    clkgen_reprog_seq #(.VAL_W(VW), .ADDR_W(AW), .DATA_W(DW), .ADDR_M(AM), .ADDR_D(AD),
                        .RDY_LIMIT(RL), .LOCK_LIMIT(LL)) dut_i (
        .clk(clk), .rst(rst), .req_start(req_start), .req_mult(req_mult), .req_div(req_div),
        .busy(busy), .done(done), .err(err), .stat_rdata(stat_rdata), .cm_rst(cm_rst),
        .drp_addr(drp_addr), .drp_wdata(drp_wdata), .drp_en(drp_en), .drp_we(drp_we),
        .drp_rdy(drp_rdy), .drp_rdata(drp_rdata), .cm_locked(cm_locked)
    );

    always #5 clk = ~clk;

    // responder model of the clock manager port
    int rdy_tmr = 0;
    bit last_we = 0;
    logic [DW-1:0] exp_rd = '0;
    always @(posedge clk) begin
        drp_rdy <= 1'b0;
        if (rst) begin
            rdy_tmr <= 0;
        end else if (drp_en && !stall) begin
            rdy_tmr <= 1 + int'($urandom_range(3));
            last_we <= drp_we;
        end else if (rdy_tmr > 0) begin
            if (rdy_tmr == 1) begin
                drp_rdy <= 1'b1;
                if (!last_we) begin
                    logic [DW-1:0] v;
                    v = DW'($urandom);
                    drp_rdata <= v;
                    exp_rd    <= v;
                end
            end
            rdy_tmr <= rdy_tmr - 1;
        end
    end

    // lock model
    int lcnt = 0;
    always @(posedge clk) begin
        if (cm_rst) begin
            cm_locked <= 1'b0;
            lcnt      <= 0;
        end else if (!cm_locked && !lock_never) begin
            lcnt <= lcnt + 1;
            if (lcnt + 1 >= lock_dly) cm_locked <= 1'b1;
        end
    end

    // access monitor
    logic [AW-1:0] log_addr [8];
    logic [DW-1:0] log_data [8];
    bit log_we [8];
    bit log_rst [8];
    int log_n = 0;
    bit outstanding = 0, out_we = 0, read_acked = 0, prev_cmrst = 0;
    int viol_overlap = 0, viol_release = 0;
    always @(posedge clk) begin
        if (!rst) begin
            if (drp_en) begin
                if (log_n < 8) begin
                    log_addr[log_n] = drp_addr;
                    log_data[log_n] = drp_wdata;
                    log_we[log_n]   = drp_we;
                    log_rst[log_n]  = cm_rst;
                end
                log_n = log_n + 1;
                if (outstanding) viol_overlap = viol_overlap + 1;
                outstanding = 1;
                out_we      = drp_we;
            end else if (drp_rdy && outstanding) begin
                outstanding = 0;
                if (!out_we) read_acked = 1;
            end
            if (prev_cmrst && !cm_rst && !read_acked) viol_release = viol_release + 1;
        end else begin
            outstanding = 0;
        end
        prev_cmrst = cm_rst;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        log_n = 0;
        read_acked = 0;
        viol_overlap = 0;
        viol_release = 0;
    endtask

    task automatic wait_end(output int cyc);
        cyc = 0;
        while (!done && !err && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_valid(input int m, input int d, input bit intrude);
        int cyc;
        @(negedge clk);
        clear_log();
        lock_dly = 3 + int'($urandom_range(17));
        req_mult = (VW+1)'(m); req_div = (VW+1)'(d); req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
        cyc = 0;
        while (!done && !err && cyc < 3000) begin
            if (intrude && cyc == 3) begin
                req_mult = (VW+1)'(3); req_div = (VW+1)'(7); req_start = 1'b1; // R8
            end else begin
                req_start = 1'b0;
            end
            if (intrude && cyc < 6) chk(busy == 1'b1, "R2 busy held", int'(busy), 1);
            @(negedge clk);
            cyc++;
        end
        req_start = 1'b0;
        chk(done == 1'b1 && err == 1'b0, "R5 done reported", int'(done), 1);
        chk(cm_locked == 1'b1, "R5 lock before done", int'(cm_locked), 1);
        chk(log_n == 3, "R3 R8 access count", log_n, 3);
        if (log_n == 3) begin
            chk(log_we[0] && log_addr[0] == AM && log_data[0] == DW'(m - 1),
                "R3 write M", int'(log_data[0]), m - 1);
            chk(log_we[1] && log_addr[1] == AD && log_data[1] == DW'(d - 1),
                "R3 write D", int'(log_data[1]), d - 1);
            chk(!log_we[2] && log_addr[2] == '0, "R3 read addr0", int'(log_addr[2]), 0);
            chk(log_rst[0] && log_rst[1] && log_rst[2], "R4 reset held",
                int'(log_rst[0]) + int'(log_rst[1]) + int'(log_rst[2]), 3);
        end
        chk(stat_rdata == exp_rd, "R7 read data", int'(stat_rdata), int'(exp_rd));
        chk(viol_overlap == 0, "R6 overlapping access", viol_overlap, 0);
        chk(viol_release == 0, "R5 early release", viol_release, 0);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R2 back to idle", int'(busy), 0);
    endtask

    task automatic run_invalid(input int m, input int d);
        @(negedge clk);
        clear_log();
        req_mult = (VW+1)'(m); req_div = (VW+1)'(d); req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(err == 1'b1 && busy == 1'b0, "R1 reject", int'(err), 1);
        @(negedge clk);
        chk(err == 1'b0, "R1 err one cycle", int'(err), 0);
        repeat (3) @(negedge clk);
        chk(log_n == 0, "R1 no access", log_n, 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'h5eed_0c1c));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0 && cm_rst == 0 && drp_en == 0,
            "R11 reset state", int'(busy), 0);
        rst = 1'b0;
        repeat (25) @(negedge clk);

        // directed corners
        run_valid(9, 4, 0);
        run_valid(2, 2, 0);
        run_valid(32, 32, 0);
        run_valid(17, 5, 1);
        run_invalid(1, 4);
        run_invalid(4, 33);
        run_invalid(0, 0);
        run_invalid(63, 2);

        // random mix
        for (int i = 0; i < 24; i++) begin
            if ($urandom_range(3) == 0) begin
                if ($urandom_range(1) == 0) run_invalid(int'($urandom_range(1)), 2 + int'($urandom_range(30)));
                else run_invalid(2 + int'($urandom_range(30)), 33 + int'($urandom_range(30)));
            end else begin
                run_valid(2 + int'($urandom_range(30)), 2 + int'($urandom_range(30)), $urandom_range(4) == 0);
            end
        end

        // ready timeout
        @(negedge clk);
        clear_log();
        stall = 1;
        req_mult = 7'd5; req_div = 7'd3; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_end(cyc);
        chk(err == 1'b1 && cm_rst == 1'b0, "R9 ready timeout", int'(err), 1);
        chk(cyc >= RL && cyc <= RL + 3, "R9 timeout window", cyc, RL + 1);
        chk(log_n == 1, "R9 no further access", log_n, 1);
        stall = 0;
        repeat (30) @(negedge clk);

        // lock timeout
        @(negedge clk);
        clear_log();
        lock_never = 1;
        req_mult = 7'd6; req_div = 7'd2; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_end(cyc);
        chk(err == 1'b1 && done == 1'b0, "R10 lock timeout", int'(err), 1);
        chk(cm_rst == 1'b0, "R10 reset released", int'(cm_rst), 0);
        lock_never = 0;
        repeat (30) @(negedge clk);
        run_valid(12, 7, 0);

        // reset mid-sequence
        @(negedge clk);
        req_mult = 7'd8; req_div = 7'd8; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0 && cm_rst == 0 && drp_en == 0,
            "R11 mid-sequence reset", int'(busy) + int'(cm_rst), 0);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        run_valid(3, 31, 0);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule